// File: doc/BRIEF.md
# RTC Calibrated Seconds Divider

This block turns a clock-enable that pulses at the crystal rate (32,768 per second at the default setting) into a one-clock pulse once per second. A signed trim value moves the long-term rate up or down. The trim works by shortening or stretching a few whole seconds at the start of each correction period of 3,840 seconds (64 minutes). Within one period, a speed-up step removes 512 crystal ticks and a slow-down step adds 256.

The same crystal ticks also feed a second, untrimmed divider. That divider makes a 512 Hz test tone on a shared output pin, so a production tester can measure the raw crystal error and work out the trim value. The pin can work as push-pull or as open-drain. In open-drain mode the block only ever drives a low and releases the pin for a high level. A hold input freezes every counter, and a power-fail input turns the test tone off.

Top module: `rtc_cal_divider`

## Requirements
- R1: With a trim magnitude of zero, `sec_tick` pulses for exactly one clock after every DIV qualified ticks. A qualified tick is a clock where `osc_tick`=1 and `hold`=0.
- R2: `trim[5]`=1 selects speed-up and `trim[4:0]` gives the magnitude m. The first 2·m seconds of the period each last DIV−CHUNK ticks, and every later second lasts DIV ticks. At the defaults this removes 512·m ticks per period.
- R3: `trim[5]`=0 selects slow-down. The first m seconds of the period each last DIV+CHUNK ticks, which adds 256·m ticks per period at the defaults.
- R4: A period is PERIOD_SECS seconds long. The block samples `trim` only on the first qualified tick of each period, so a change made during a period takes effect at the start of the next one.
- R5: While `hold`=1, the seconds counter, the period counter and the tone divider keep their values, and `sec_tick` stays 0.
- R6: The tone level starts low and inverts after every TONE_HALF qualified ticks, which gives 512 Hz at the defaults. The pin carries this tone when `hold`=0, `tone_req`=1, `pwr_fail`=0 and `sqw_req`=0. The tone does not depend on `trim`.
- R7: While `pwr_fail`=1, the tone is off and the pin is in its idle state.
- R8: When `od_mode`=1, `pin_data` is 0 and `pin_oe` is the inverse of the level. When `od_mode`=0, `pin_oe` is 1 and `pin_data` is the level.
- R9: When the test tone is not selected, the level is 1. The pin is then released in open-drain mode and driven high in push-pull mode.
- R10: Asserting `rst_n` low clears the block at once, without waiting for a clock. `sec_tick` goes to 0 and all counters and the tone level go to 0. The next qualified tick starts a new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-clock enable per crystal cycle |
| hold | input | 1 | Stops all counting when 1 |
| tone_req | input | 1 | Requests the 512 Hz test tone |
| pwr_fail | input | 1 | Power-down indication; suppresses the tone |
| sqw_req | input | 1 | Square-wave mode request; blocks the tone |
| od_mode | input | 1 | 1 = open-drain pin, 0 = push-pull |
| trim | input | 6 | Bit 5 = 1 selects speed-up; bits 4:0 give the step count |
| sec_tick | output | 1 | One-clock pulse per second |
| pin_data | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
`sec_tick` comes from a register. It is therefore due one clock after the qualified tick that ends a second. The pin outputs are combinational from the inputs and the tone register, so they respond to a mode change in the same cycle. A tone inversion shows on the pin one clock after the tick that causes it. The bench changes its inputs one nanosecond after the falling edge. It updates a behavioural model at the rising edge and compares all three outputs with the model at the next falling edge, so every expected value lines up with the register stages in between.

// File: rtl/rtc_cal_divider.sv
module rtc_cal_divider #(
  parameter int DIV           = 32768,
  parameter int CHUNK         = 256,
  parameter int FAST_PER_STEP = 2,
  parameter int SLOW_PER_STEP = 1,
  parameter int PERIOD_SECS   = 3840,
  parameter int TONE_HALF     = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       hold,
  input  logic       tone_req,
  input  logic       pwr_fail,
  input  logic       sqw_req,
  input  logic       od_mode,
  input  logic [5:0] trim,
  output logic       sec_tick,
  output logic       pin_data,
  output logic       pin_oe
);
  localparam int PW = $clog2(DIV + CHUNK);
  localparam int SW = $clog2(PERIOD_SECS);
  localparam int TW = (TONE_HALF > 1) ? $clog2(TONE_HALF) : 1;
  localparam int AW = SW + 8;
  localparam logic [PW-1:0] LAST_NOM  = PW'(DIV - 1);
  localparam logic [PW-1:0] LAST_FAST = PW'(DIV - CHUNK - 1);
  localparam logic [PW-1:0] LAST_SLOW = PW'(DIV + CHUNK - 1);

  logic [PW-1:0] pre_cnt;
  logic [SW-1:0] sec_idx;
  logic [5:0]    trim_q;
  logic [TW-1:0] tone_cnt;
  logic          tone;

  wire run       = osc_tick & ~hold;
  wire per_start = (pre_cnt == '0) && (sec_idx == '0);
  wire [5:0] trim_use = per_start ? trim : trim_q;
  wire speed_up  = trim_use[5];

  logic [AW-1:0] adj_secs;
  assign adj_secs = speed_up ? AW'(trim_use[4:0]) * AW'(FAST_PER_STEP)
                             : AW'(trim_use[4:0]) * AW'(SLOW_PER_STEP);

  wire in_adj = AW'(sec_idx) < adj_secs;
  wire [PW-1:0] last_cnt = !in_adj ? LAST_NOM : (speed_up ? LAST_FAST : LAST_SLOW);
  wire sec_end  = pre_cnt == last_cnt;
  wire tone_end = tone_cnt == TW'(TONE_HALF - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      sec_idx  <= '0;
      trim_q   <= '0;
      tone_cnt <= '0;
      tone     <= 1'b0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= run && sec_end;
      if (run) begin
        if (per_start) trim_q <= trim;
        pre_cnt <= sec_end ? '0 : pre_cnt + 1'b1;
        if (sec_end)
          sec_idx <= (sec_idx == SW'(PERIOD_SECS - 1)) ? '0 : sec_idx + 1'b1;
        tone_cnt <= tone_end ? '0 : tone_cnt + 1'b1;
        if (tone_end) tone <= ~tone;
      end
    end
  end

  wire test_on = ~hold & tone_req & ~pwr_fail & ~sqw_req;
  wire level   = test_on ? tone : 1'b1;

  assign pin_data = od_mode ? 1'b0 : level;
  assign pin_oe   = od_mode ? ~level : 1'b1;
endmodule

module rtc_cal_divider_chk #(
  parameter int DIV   = 32768,
  parameter int CHUNK = 256
) (
  input logic clk,
  input logic rst_n,
  input logic osc_tick,
  input logic hold,
  input logic tone_req,
  input logic pwr_fail,
  input logic sqw_req,
  input logic od_mode,
  input logic sec_tick,
  input logic pin_data,
  input logic pin_oe
);
  logic [31:0] q_cnt;
  wire q = osc_tick & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_cnt <= '0;
    else        q_cnt <= (sec_tick ? 32'd0 : q_cnt) + (q ? 32'd1 : 32'd0);
  end

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  // R3 shares this window with R2
  p_second_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (q_cnt >= 32'(DIV - CHUNK) && q_cnt <= 32'(DIV + CHUNK)));

  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !sec_tick);

  p_pwr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> (od_mode ? !pin_oe : (pin_oe && pin_data)));

  p_od_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    od_mode |-> !pin_data);

  p_push_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !od_mode |-> pin_oe);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tone_req && !pwr_fail && !hold && !sqw_req) |->
      (od_mode ? !pin_oe : (pin_oe && pin_data)));
endmodule

bind rtc_cal_divider rtc_cal_divider_chk #(.DIV(DIV), .CHUNK(CHUNK)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .hold(hold),
  .tone_req(tone_req), .pwr_fail(pwr_fail), .sqw_req(sqw_req),
  .od_mode(od_mode), .sec_tick(sec_tick), .pin_data(pin_data), .pin_oe(pin_oe)
);

// File: tb/test_rtc_cal_divider.sv
`timescale 1ns/1ps
module test_rtc_cal_divider;
  localparam int DIV = 32, CHUNK = 4, PSECS = 70, TH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_tick = 1'b0, hold = 1'b0, tone_req = 1'b0, pwr_fail = 1'b0;
  logic sqw_req = 1'b0, od_mode = 1'b0;
  logic [5:0] trim = 6'd0;
  logic sec_tick, pin_data, pin_oe;

  int vectors = 0, errors = 0, cyc = 0;
  bit sparse = 0;
  string tag = "R10";

  rtc_cal_divider #(.DIV(DIV), .CHUNK(CHUNK), .PERIOD_SECS(PSECS), .TONE_HALF(TH)) i_rtc_cal_divider (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .hold(hold), .tone_req(tone_req),
    .pwr_fail(pwr_fail), .sqw_req(sqw_req), .od_mode(od_mode), .trim(trim),
    .sec_tick(sec_tick), .pin_data(pin_data), .pin_oe(pin_oe));

  always #2.5 clk = ~clk;

  int m_pc = 0, m_sec = 0, m_tc = 0;
  int m_trim = 0;
  bit m_tone = 0, m_tick = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_sec = 0; m_tc = 0; m_trim = 0; m_tone = 0; m_tick = 0;
    end else begin
      int len, nadj;
      m_tick = 0;
      if (osc_tick && !hold) begin
        if (m_pc == 0 && m_sec == 0) m_trim = int'(trim);
        nadj = (m_trim >= 32) ? 2 * (m_trim - 32) : m_trim;
        len = DIV;
        if (m_sec < nadj) len = (m_trim >= 32) ? DIV - CHUNK : DIV + CHUNK;
        m_pc = m_pc + 1;
        if (m_pc == len) begin
          m_pc = 0; m_tick = 1;
          m_sec = (m_sec + 1) % PSECS;
        end
        m_tc = m_tc + 1;
        if (m_tc == TH) begin m_tc = 0; m_tone = !m_tone; end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit lvl;
      lvl = (!hold && tone_req && !pwr_fail && !sqw_req) ? m_tone : 1'b1;
      check(tag, "sec_tick", int'(sec_tick), int'(m_tick));
      check(tag, "pin_data", int'(pin_data), od_mode ? 0 : int'(lvl));
      check(tag, "pin_oe",   int'(pin_oe),   od_mode ? int'(!lvl) : 1);
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      cyc++;
      osc_tick = sparse ? ((cyc % 3) != 0) : 1'b1;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: state while reset is held
    check("R10", "sec_tick in reset", int'(sec_tick), 0);
    check("R10", "pin_oe in reset", int'(pin_oe), 1);
    check("R10", "pin_data in reset", int'(pin_data), 1);
    #1 rst_n = 1'b1;

    tag = "R1";  run(PSECS * DIV + 10);
    tag = "R2";  trim = 6'b100011; run(2 * PSECS * DIV);
    tag = "R4";  trim = 6'b000101; run(PSECS * DIV / 2);
    trim = 6'b100001; run(PSECS * DIV * 2);
    tag = "R3";  trim = 6'b011111; sparse = 1; run(3 * PSECS * DIV); sparse = 0;
    tag = "R5";  hold = 1; run(200); hold = 0; run(100);
    tag = "R6";  tone_req = 1; run(300); trim = 6'b111111; run(300);
    tag = "R8";  od_mode = 1; run(200);
    tag = "R7";  pwr_fail = 1; run(100); pwr_fail = 0; run(50);
    tag = "R9";  sqw_req = 1; run(100); od_mode = 0; run(100); sqw_req = 0;
    hold = 1; run(50); hold = 0; run(50);

    tag = "R10";
    run(37);
    rst_n = 1'b0; #1;
    check("R10", "sec_tick after async reset", int'(sec_tick), 0);
    check("R10", "pin_data after async reset", int'(pin_data), 0);
    @(negedge clk); #1 rst_n = 1'b1;
    run(3 * DIV);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule